// File: doc/BRIEF.md
# Pipelined Address Bus Cycle Controller

This block is the bus-master end of a processor's external bus. It takes transfer requests from an internal queue through a valid/accept handshake and turns each one into a bus cycle. For each cycle it drives the address, the byte enables and three cycle-definition flags: memory or I/O, data or control, and write or read. Each bus state lasts one clock. A cycle spends one clock in its address state. It then stays in a data state until the ready input ends it.

The address state samples a next-address input. If that input is high and another request is already waiting, the block accepts that request straight away and drives its address and definition while the current cycle is still in its data state. The current cycle then ends in the pipelined data state, and the announced cycle's address state follows directly, so back-to-back transfers take two clocks each. If no request is waiting, the current cycle ends in the idle-pipelined data state and the bus definition stays as it is. The data bus is split into an input, an output and an output enable. The enable is low for reads and high for writes. Read data is latched on the ending ready and is handed back with a one-clock valid pulse.

Top module: `pipe_bus_master`

## Requirements
- R1: After a synchronous active-high reset, req_ready is high, bus_doe and rd_valid are low, and all bus outputs are zero.
- R2: When idle, a request with req_valid high is accepted in that clock. Its address, byte enables and flags appear on the bus outputs after the next rising edge, and that cycle's address state begins there.
- R3: In the address state, if next_addr and req_valid are both high, the waiting request is accepted and its address and flags appear on the bus outputs after that edge. The current cycle continues in the pipelined data state.
- R4: In the address state with req_valid low, nothing is accepted and the bus outputs keep their values for any level of next_addr. The cycle continues in the idle-pipelined data state.
- R5: bus_ready is ignored in the address state. No read data is captured and the cycle does not end there.
- R6: While a data state sees bus_ready low, the bus outputs, bus_dout and bus_doe hold their values and req_ready is low (wait states).
- R7: In a read cycle bus_doe is low. On the ending bus_ready, bus_din is latched, and rd_data shows it with rd_valid high for exactly the one following clock.
- R8: In a write cycle, bus_doe is high and bus_dout carries that request's write data from the cycle's address state until it ends.
- R9: bus_ready in the pipelined data state is followed at once by the address state of the announced cycle, whose write/read kind then sets bus_doe and bus_dout.
- R10: bus_ready in the idle-pipelined data state returns the block to idle with bus_doe low when req_valid is low. When req_valid is high, that request is accepted and its address state follows directly.
- R11: req_ready is high only when idle, in the address state with next_addr high, or in the idle-pipelined data state with bus_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken this clock |
| req_addr | input | AW | Request address |
| req_be | input | BE_W | Request byte enables |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_data_cyc | input | 1 | 1 = data cycle, 0 = control cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| next_addr | input | 1 | Next-address request from the bus, sampled in the address state |
| bus_ready | input | 1 | Transfer-complete input from the bus |
| bus_addr | output | AW | Bus address |
| bus_be | output | BE_W | Bus byte enables |
| bus_mem | output | 1 | Bus memory/I/O flag |
| bus_data_cyc | output | 1 | Bus data/control flag |
| bus_write | output | 1 | Bus write/read flag |
| bus_din | input | DW | Data bus input |
| bus_dout | output | DW | Data bus output |
| bus_doe | output | 1 | Data bus output enable |
| rd_valid | output | 1 | One-clock pulse: read data returned |
| rd_data | output | DW | Captured read data |

## Verification
Three things can happen at the same edge. In the address state of a write, the next request's definition can be accepted while the current write data stays on the bus. When the pipelined data state ends, the read capture of one cycle and the start of the next cycle share that edge. When the idle-pipelined state ends with a request waiting, the completion and a new acceptance share that edge. The bench provokes these cases with a phase that keeps next_addr, bus_ready and req_valid high, so reads and writes follow each other at two clocks apart. A random phase adds bus_ready during address states and sparse requests. A behavioural model that steps state by state checks every output on every clock, so a capture taken from the wrong cycle, or write data taken from the announced cycle instead of the current one, shows up at once.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DPIPE = 2'd2,
    PH_DIDLE = 2'd3
  } phase_t;
endpackage

// File: rtl/pbm_fsm.sv
module pbm_fsm
  import pbm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   next_addr,
  input  logic   bus_ready,
  output phase_t phase,
  output logic   req_ready,
  output logic   accept,
  output logic   cyc_start,
  output logic   cyc_done,
  output logic   go_idle
);
  phase_t phase_nx;

  always_comb begin
    req_ready = (phase == PH_IDLE) ||
                ((phase == PH_ADDR) && next_addr) ||
                ((phase == PH_DIDLE) && bus_ready);
    accept    = req_valid && req_ready;
    cyc_done  = ((phase == PH_DPIPE) || (phase == PH_DIDLE)) && bus_ready;
    cyc_start = ((phase == PH_IDLE) && req_valid) ||
                ((phase == PH_DPIPE) && bus_ready) ||
                ((phase == PH_DIDLE) && bus_ready && req_valid);
    go_idle   = (phase == PH_DIDLE) && bus_ready && !req_valid;
    phase_nx  = phase;
    case (phase)
      PH_IDLE:  if (req_valid) phase_nx = PH_ADDR;
      PH_ADDR:  phase_nx = (req_valid && next_addr) ? PH_DPIPE : PH_DIDLE;
      PH_DPIPE: if (bus_ready) phase_nx = PH_ADDR;
      PH_DIDLE: if (bus_ready) phase_nx = req_valid ? PH_ADDR : PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end
endmodule

// File: rtl/pbm_defreg.sv
module pbm_defreg
  import pbm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_t          phase,
  input  logic            bus_ready,
  input  logic            accept,
  input  logic            cyc_start,
  input  logic            go_idle,
  input  logic [AW-1:0]   req_addr,
  input  logic [BE_W-1:0] req_be,
  input  logic            req_mem,
  input  logic            req_data_cyc,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  output logic [AW-1:0]   bus_addr,
  output logic [BE_W-1:0] bus_be,
  output logic            bus_mem,
  output logic            bus_data_cyc,
  output logic            bus_write,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_doe
);
  logic [DW-1:0] held_wdata;
  logic          start_wr;
  logic [DW-1:0] start_wdata;

  always_comb begin
    start_wr    = accept ? req_write : bus_write;
    start_wdata = accept ? req_wdata : held_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr     <= '0;
      bus_be       <= '0;
      bus_mem      <= 1'b0;
      bus_data_cyc <= 1'b0;
      bus_write    <= 1'b0;
      held_wdata   <= '0;
      bus_dout     <= '0;
      bus_doe      <= 1'b0;
    end else begin
      if (accept) begin
        bus_addr     <= req_addr;
        bus_be       <= req_be;
        bus_mem      <= req_mem;
        bus_data_cyc <= req_data_cyc;
        bus_write    <= req_write;
        held_wdata   <= req_wdata;
      end
      if (cyc_start) begin
        bus_doe  <= start_wr;
        bus_dout <= start_wdata;
      end else if (go_idle) begin
        bus_doe  <= 1'b0;
      end
    end
  end

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (((phase == PH_DPIPE) || (phase == PH_DIDLE)) && !bus_ready) |=>
      ($stable(bus_addr) && $stable(bus_write) && $stable(bus_dout) && $stable(bus_doe)));
endmodule

// File: rtl/pbm_rdcap.sv
module pbm_rdcap
  import pbm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic          cyc_done,
  input  logic          cur_write,
  input  logic [DW-1:0] bus_din,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cyc_done && !cur_write;
      if (cyc_done && !cur_write) rd_data <= bus_din;
    end
  end

  assert_rdv_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_no_end_in_addr_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (($past(phase) == PH_DPIPE) || ($past(phase) == PH_DIDLE)));
endmodule

// File: rtl/pipe_bus_master.sv
module pipe_bus_master
  import pbm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [BE_W-1:0] req_be,
  input  logic            req_mem,
  input  logic            req_data_cyc,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  input  logic            next_addr,
  input  logic            bus_ready,
  output logic [AW-1:0]   bus_addr,
  output logic [BE_W-1:0] bus_be,
  output logic            bus_mem,
  output logic            bus_data_cyc,
  output logic            bus_write,
  input  logic [DW-1:0]   bus_din,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_doe,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  phase_t phase;
  logic   accept, cyc_start, cyc_done, go_idle;

  pbm_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .next_addr(next_addr),
    .bus_ready(bus_ready), .phase(phase), .req_ready(req_ready),
    .accept(accept), .cyc_start(cyc_start), .cyc_done(cyc_done),
    .go_idle(go_idle)
  );

  pbm_defreg #(.AW(AW), .DW(DW), .BE_W(BE_W)) u_def (
    .clk(clk), .rst(rst), .phase(phase), .bus_ready(bus_ready),
    .accept(accept), .cyc_start(cyc_start), .go_idle(go_idle),
    .req_addr(req_addr), .req_be(req_be), .req_mem(req_mem),
    .req_data_cyc(req_data_cyc), .req_write(req_write), .req_wdata(req_wdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_mem(bus_mem),
    .bus_data_cyc(bus_data_cyc), .bus_write(bus_write),
    .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  // In an active cycle the output enable marks a write.
  pbm_rdcap #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .phase(phase), .cyc_done(cyc_done),
    .cur_write(bus_doe), .bus_din(bus_din),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DPIPE) |-> !req_ready);
  assert_idle_float_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !bus_doe);
endmodule

// File: tb/test_pipe_bus_master.sv
`timescale 1ns/1ps
module test_pipe_bus_master;
  localparam int AW = 32, DW = 32, BE_W = 4;
  localparam int NCYC = 4000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_mem = 1'b0, req_data_cyc = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BE_W-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic next_addr = 1'b0, bus_ready = 1'b0;
  logic req_ready, bus_mem, bus_data_cyc, bus_write, bus_doe, rd_valid;
  logic [AW-1:0] bus_addr;
  logic [BE_W-1:0] bus_be;
  logic [DW-1:0] bus_dout, rd_data;

  always #2 clk = ~clk;

  pipe_bus_master #(.AW(AW), .DW(DW), .BE_W(BE_W)) i_pipe_bus_master (.*);

  int errors = 0, checks = 0;
  int n_pipe = 0, n_t2i = 0, n_t1rdy = 0, n_wait = 0, n_rd = 0, n_wr = 0;
  bit finished = 0;

  // Behavioural reference: 0 idle, 1 address, 2 pipelined data, 3 idle-pipelined data
  int m_ph = 0;
  logic [AW-1:0] m_addr; logic [BE_W-1:0] m_be;
  logic m_mem, m_dc, m_wr, m_oe, m_rdv;
  logic [DW-1:0] m_wd, m_dout, m_rdd;
  bit m_acc;

  function automatic bit m_ready();
    return (m_ph == 0) || (m_ph == 1 && next_addr) || (m_ph == 3 && bus_ready);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_addr = '0; m_be = '0; m_mem = 0; m_dc = 0; m_wr = 0;
      m_wd = '0; m_dout = '0; m_oe = 0; m_rdv = 0; m_rdd = '0; m_acc = 0;
    end else begin
      bit acc, done, start;
      acc = req_valid && m_ready();
      done = (m_ph == 2 || m_ph == 3) && bus_ready;
      start = 0;
      m_rdv = 0;
      if (done && !m_oe) begin m_rdv = 1; m_rdd = bus_din; n_rd++; end
      if (done && m_oe) n_wr++;
      if (m_ph == 1 && bus_ready) n_t1rdy++;
      if ((m_ph == 2 || m_ph == 3) && !bus_ready) n_wait++;
      if (acc) begin
        m_addr = req_addr; m_be = req_be; m_mem = req_mem; m_dc = req_data_cyc;
        m_wr = req_write; m_wd = req_wdata;
      end
      case (m_ph)
        0: if (req_valid) begin m_ph = 1; start = 1; end
        1: begin
             if (acc) begin m_ph = 2; n_pipe++; end
             else begin m_ph = 3; n_t2i++; end
           end
        2: if (bus_ready) begin m_ph = 1; start = 1; end
        default: if (bus_ready) begin
             if (req_valid) begin m_ph = 1; start = 1; end
             else begin m_ph = 0; m_oe = 0; end
           end
      endcase
      if (start) begin m_oe = m_wr; m_dout = m_wd; end
      m_acc = acc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", req, what, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(req_ready === m_ready(), "R11", "req_ready", 64'(req_ready), 64'(m_ready()));
    chk(bus_addr === m_addr, "R2/R3/R4/R6", "bus_addr", 64'(bus_addr), 64'(m_addr));
    chk(bus_be === m_be && bus_mem === m_mem && bus_data_cyc === m_dc && bus_write === m_wr,
        "R2/R3/R4", "definition", {bus_be, bus_mem, bus_data_cyc, bus_write},
        {m_be, m_mem, m_dc, m_wr});
    chk(bus_doe === m_oe, "R7/R8/R10", "bus_doe", 64'(bus_doe), 64'(m_oe));
    chk(bus_dout === m_dout, "R8/R9", "bus_dout", 64'(bus_dout), 64'(m_dout));
    chk(rd_valid === m_rdv, "R5/R7", "rd_valid", 64'(rd_valid), 64'(m_rdv));
    chk(rd_data === m_rdd, "R7", "rd_data", 64'(rd_data), 64'(m_rdd));
  endtask

  task automatic new_req();
    req_addr = $urandom; req_be = BE_W'($urandom); req_mem = $urandom;
    req_data_cyc = $urandom; req_write = $urandom; req_wdata = $urandom;
  endtask

  initial begin
    void'($urandom(7));
    new_req();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(req_ready === 1'b1 && bus_doe === 1'b0 && rd_valid === 1'b0 && bus_addr === '0,
        "R1", "reset state", {req_ready, bus_doe, rd_valid}, 64'b100);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NCYC; c++) begin
      int mode;
      mode = (c < 300) ? 0 : (c < 2500) ? 1 : 2;
      if (m_acc) begin new_req(); req_valid = 1'b0; end
      if (!req_valid)
        req_valid = (mode == 0) ? 1'b1 : (mode == 1) ? ($urandom % 3 != 0) : ($urandom % 5 == 0);
      next_addr = (mode == 0) ? 1'b1 : (mode == 1) ? ($urandom % 2 == 0) : ($urandom % 6 == 0);
      bus_ready = (mode == 0) ? 1'b1 : ($urandom % 3 != 0);
      bus_din = $urandom;
      #1;
      compare_all();
      @(negedge clk);
    end
    chk(n_pipe > 0, "R3", "pipelined announcements seen", 64'(n_pipe), 64'd1);
    chk(n_t2i > 0, "R4", "idle-pipelined states seen", 64'(n_t2i), 64'd1);
    chk(n_t1rdy > 0, "R5", "ready in address state seen", 64'(n_t1rdy), 64'd1);
    chk(n_wait > 0, "R6", "wait states seen", 64'(n_wait), 64'd1);
    chk(n_rd > 0 && n_wr > 0, "R7/R8/R9/R10", "reads and writes done",
        64'(n_rd), 64'(n_wr));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule